// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block picks which of a fixed set of memory frames should be evicted next. It keeps two status flags per frame. The "recently used" flag is raised whenever the frame is touched. The "modified" flag is raised when the frame is written. Access events raise these flags through a marking port. A second port tells the block that a write-back has finished, which lowers the modified flag of the frame it names.

When the owner wants a frame, it presents a request on a valid/ready port. A hand pointer then walks around the frames in a circle, one frame per clock cycle:

- A recently used frame has its flag lowered and is passed over.
- An unused but modified frame gets a one-cycle write-back request pulse and is passed over, so unmodified frames are preferred.
- The first frame that is neither recently used nor modified becomes the victim.

If two full turns of the hand find no such frame, the frame under the hand is taken anyway and the result is flagged as forced. The result is offered on a valid/ready port and is held until it is taken. A new request is accepted only when the block is idle, with no result pending, so back-pressure on the result stalls the request side as well.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every frame flag is clear and the hand points at frame 0. `req_ready` is 1, while `vic_valid` and `wb_req_valid` are 0. A first request with no marks therefore picks frame 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the result has been taken.
- R3: The sweep examines exactly one frame per cycle. `vic_valid` first rises m clock edges after the accepting edge, where m is the number of frames examined, the victim included.
- R4: A frame examined with its used flag at 1 has that flag lowered. The hand moves to the next frame and no write-back pulse is produced for it.
- R5: The first examined frame with both flags at 0 is returned on `vic_idx` with `vic_forced` = 0. The hand is left at the next frame (index + 1, wrapping from N-1 to 0).
- R6: A frame examined with used = 0 and modified = 1 is not chosen. `wb_req_valid` is 1 for exactly one cycle, on the cycle after the examining edge, with `wb_req_idx` naming that frame.
- R7: `acc_valid` raises the used flag of frame `acc_idx`. When `acc_write` is also 1, it raises that frame's modified flag too.
- R8: `wb_done_valid` lowers the modified flag of frame `wb_done_idx`. A frame whose flag was lowered this way can then be chosen as a clean victim.
- R9: When an access marks a frame on the same edge at which the sweep lowers that frame's used flag, the flag stays at 1.
- R10: When 2·N frames have been examined without a victim, the next examined frame is chosen whatever its flags. It is returned with `vic_forced` = 1, 2·N+1 edges after acceptance.
- R11: While `vic_valid` is 1 and `vic_ready` is 0, `vic_valid`, `vic_idx` and `vic_forced` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event marking a frame as used |
| acc_idx | input | IDX_W | Frame touched by the access |
| acc_write | input | 1 | Access is a write: also marks the frame modified |
| wb_done_valid | input | 1 | A write-back has finished |
| wb_done_idx | input | IDX_W | Frame whose write-back finished |
| req_valid | input | 1 | Victim request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| vic_valid | output | 1 | Victim result offered |
| vic_ready | input | 1 | Consumer takes the result |
| vic_idx | output | IDX_W | Chosen frame |
| vic_forced | output | 1 | Victim taken after two fruitless turns |
| wb_req_valid | output | 1 | One-cycle write-back request pulse |
| wb_req_idx | output | IDX_W | Frame to write back |

## Verification
The bench counts cycles from the edge that accepts a request. It checks that `vic_valid` rises after exactly as many edges as its own model of the sweep examines frames: one for an immediate victim, and 2·N+1 for a forced one. Write-back pulses are expected one cycle after the frame is examined. The monitor compares them in arrival order against the model's list, so a missing, extra or late pulse is reported. All outputs are sampled on the falling edge. The marking strobe used for the same-edge conflict is driven so that it lands on the very edge that examines that frame.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_SCAN = 2'd1,
    SW_DONE = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/cvs_frame_flags.sv
module cvs_frame_flags #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic                  acc_write,
  input  logic                  wb_done_valid,
  input  logic [IDX_W-1:0]      wb_done_idx,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NUM_FRAMES-1:0] used_bits,
  output logic [NUM_FRAMES-1:0] mod_bits
);

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic hit_acc, hit_clr, hit_wb;
    assign hit_acc = acc_valid && (acc_idx == IDX_W'(g));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
    assign hit_wb  = wb_done_valid && (wb_done_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_bits[g] <= 1'b0;
        mod_bits[g]  <= 1'b0;
      end else begin
        // a fresh mark overrides the sweep clearing the same frame
        if (hit_acc)      used_bits[g] <= 1'b1;
        else if (hit_clr) used_bits[g] <= 1'b0;
        if (hit_acc && acc_write) mod_bits[g] <= 1'b1;
        else if (hit_wb)          mod_bits[g] <= 1'b0;
      end
    end
  end

  // R7, R9: any access leaves the used flag raised, even against a sweep clear
  assert_mark_sets_used_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> used_bits[$past(acc_idx)]);

  // R8: finished write-back leaves the frame clean unless rewritten that edge
  assert_wb_clears_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done_valid && !(acc_valid && acc_write && acc_idx == wb_done_idx))
      |=> !mod_bits[$past(wb_done_idx)]);

endmodule

// File: rtl/cvs_hand_sweep.sv
module cvs_hand_sweep
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int LIMIT = 2 * NUM_FRAMES,
  localparam int STEP_W = $clog2(LIMIT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  vic_ready,
  input  logic [NUM_FRAMES-1:0] used_bits,
  input  logic [NUM_FRAMES-1:0] mod_bits,
  output logic                  clr_en,
  output logic [IDX_W-1:0]      clr_idx,
  output logic                  vic_valid,
  output logic [IDX_W-1:0]      vic_idx,
  output logic                  vic_forced,
  output logic                  wb_req_valid,
  output logic [IDX_W-1:0]      wb_req_idx
);

  sweep_state_e     state_q;
  logic [IDX_W-1:0] hand_q, hand_nxt;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0] vic_idx_q;
  logic             forced_q;
  logic             wb_v_q;
  logic [IDX_W-1:0] wb_idx_q;

  logic scanning, at_limit, cur_used, cur_mod, pick, wb_hit;

  always_comb begin
    scanning = (state_q == SW_SCAN);
    at_limit = (step_q == STEP_W'(LIMIT));
    cur_used = used_bits[hand_q];
    cur_mod  = mod_bits[hand_q];
    pick     = scanning && (at_limit || (!cur_used && !cur_mod));
    clr_en   = scanning && !at_limit && cur_used;
    clr_idx  = hand_q;
    wb_hit   = scanning && !at_limit && !cur_used && cur_mod;
    hand_nxt = (hand_q == IDX_W'(NUM_FRAMES - 1)) ? '0 : hand_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SW_IDLE;
      hand_q    <= '0;
      step_q    <= '0;
      vic_idx_q <= '0;
      forced_q  <= 1'b0;
      wb_v_q    <= 1'b0;
      wb_idx_q  <= '0;
    end else begin
      wb_v_q <= wb_hit;
      if (wb_hit) wb_idx_q <= hand_q;
      case (state_q)
        SW_IDLE: begin
          if (req_valid) begin
            state_q <= SW_SCAN;
            step_q  <= '0;
          end
        end
        SW_SCAN: begin
          hand_q <= hand_nxt;
          step_q <= step_q + STEP_W'(1);
          if (pick) begin
            vic_idx_q <= hand_q;
            forced_q  <= at_limit;
            state_q   <= SW_DONE;
          end
        end
        SW_DONE: begin
          if (vic_ready) state_q <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == SW_IDLE);
  assign vic_valid    = (state_q == SW_DONE);
  assign vic_idx      = vic_idx_q;
  assign vic_forced   = forced_q;
  assign wb_req_valid = wb_v_q;
  assign wb_req_idx   = wb_idx_q;

  // R11: a stalled result does not move
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_idx) && $stable(vic_forced)));

  // R2: after acceptance the port closes and no result is yet offered
  assert_accept_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !vic_valid));

  // R6: back-to-back write-back pulses name consecutive frames around the circle
  assert_wb_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && $past(wb_req_valid)) |->
      (wb_req_idx == (($past(wb_req_idx) == IDX_W'(NUM_FRAMES - 1)) ? '0
                       : $past(wb_req_idx) + IDX_W'(1))));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_write,
  input  logic             wb_done_valid,
  input  logic [IDX_W-1:0] wb_done_idx,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_forced,
  output logic             wb_req_valid,
  output logic [IDX_W-1:0] wb_req_idx
);

  logic [NUM_FRAMES-1:0] used_bits;
  logic [NUM_FRAMES-1:0] mod_bits;
  logic                  clr_en;
  logic [IDX_W-1:0]      clr_idx;

  cvs_frame_flags #(.NUM_FRAMES(NUM_FRAMES)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_idx       (acc_idx),
    .acc_write     (acc_write),
    .wb_done_valid (wb_done_valid),
    .wb_done_idx   (wb_done_idx),
    .clr_en        (clr_en),
    .clr_idx       (clr_idx),
    .used_bits     (used_bits),
    .mod_bits      (mod_bits)
  );

  cvs_hand_sweep #(.NUM_FRAMES(NUM_FRAMES)) u_sweep (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .vic_ready    (vic_ready),
    .used_bits    (used_bits),
    .mod_bits     (mod_bits),
    .clr_en       (clr_en),
    .clr_idx      (clr_idx),
    .vic_valid    (vic_valid),
    .vic_idx      (vic_idx),
    .vic_forced   (vic_forced),
    .wb_req_valid (wb_req_valid),
    .wb_req_idx   (wb_req_idx)
  );

  // R3/R5: a result appears only after the port has been closed by a request
  assert_result_after_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vic_valid) |-> !$past(req_ready));

endmodule

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
  localparam int NF = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic wb_done_valid = 1'b0;
  logic [IW-1:0] wb_done_idx = '0;
  logic req_valid = 1'b0;
  logic vic_ready = 1'b1;
  logic req_ready, vic_valid, vic_forced, wb_req_valid;
  logic [IW-1:0] vic_idx, wb_req_idx;

  clock_victim_sel #(.NUM_FRAMES(NF)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_write(acc_write), .wb_done_valid(wb_done_valid), .wb_done_idx(wb_done_idx),
    .req_valid(req_valid), .req_ready(req_ready), .vic_valid(vic_valid),
    .vic_ready(vic_ready), .vic_idx(vic_idx), .vic_forced(vic_forced),
    .wb_req_valid(wb_req_valid), .wb_req_idx(wb_req_idx));

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, pops = 0, acc_cyc = 0;
  bit finished = 0, prev_v = 0;

  // reference model of the frame flags and hand
  int m_used[NF], m_mod[NF], m_hand;
  int exp_idx[$], exp_forced[$], exp_lat[$], wbq[$];
  string exp_tag[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt(int h);
    return (h == NF - 1) ? 0 : h + 1;
  endfunction

  function automatic void predict(string tag);
    int steps = 0;
    bit done = 0;
    while (!done) begin
      if (steps == 2 * NF) begin
        exp_idx.push_back(m_hand); exp_forced.push_back(1);
        exp_lat.push_back(steps + 1); exp_tag.push_back(tag);
        m_hand = nxt(m_hand); done = 1;
      end else if (m_used[m_hand] != 0) begin
        m_used[m_hand] = 0; m_hand = nxt(m_hand); steps++;
      end else if (m_mod[m_hand] != 0) begin
        wbq.push_back(m_hand); m_hand = nxt(m_hand); steps++;
      end else begin
        exp_idx.push_back(m_hand); exp_forced.push_back(0);
        exp_lat.push_back(steps + 1); exp_tag.push_back(tag);
        m_hand = nxt(m_hand); done = 1;
      end
    end
  endfunction

  // monitor: compares results and write-back pulses as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (vic_valid && !prev_v) begin
        if (exp_lat.size() == 0)
          check(0, "R3", "unexpected result", int'(vic_idx), -1);
        else
          check(cyc - acc_cyc == exp_lat[0], "R3", {exp_tag[0], " latency"},
                cyc - acc_cyc, exp_lat[0]);
      end
      if (vic_valid && vic_ready && exp_idx.size() != 0) begin
        check(int'(vic_idx) == exp_idx[0], exp_tag[0], "victim index",
              int'(vic_idx), exp_idx[0]);
        check(int'(vic_forced) == exp_forced[0], "R10", {exp_tag[0], " forced flag"},
              int'(vic_forced), exp_forced[0]);
        void'(exp_idx.pop_front()); void'(exp_forced.pop_front());
        void'(exp_lat.pop_front()); void'(exp_tag.pop_front());
        pops++;
      end
      if (wb_req_valid) begin
        if (wbq.size() == 0) check(0, "R6", "unexpected write-back", int'(wb_req_idx), -1);
        else begin
          check(int'(wb_req_idx) == wbq[0], "R6", "write-back index", int'(wb_req_idx), wbq[0]);
          void'(wbq.pop_front());
        end
      end
      prev_v = vic_valid;
    end else prev_v = 0;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NF; i++) begin m_used[i] = 0; m_mod[i] = 0; end
    m_hand = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic mark(int idx, bit wr);
    acc_valid = 1'b1; acc_idx = IW'(idx); acc_write = wr;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
    m_used[idx] = 1;
    if (wr) m_mod[idx] = 1;
  endtask

  task automatic ack(int idx);
    wb_done_valid = 1'b1; wb_done_idx = IW'(idx);
    @(posedge clk); #1;
    wb_done_valid = 1'b0;
    m_mod[idx] = 0;
  endtask

  // driver: predicts, issues one request, optionally stalls the result
  task automatic request(string tag, int hold, int conc);
    int target = pops + 1;
    logic [IW-1:0] held;
    predict(tag);
    vic_ready = (hold == 0);
    req_valid = 1'b1;
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    acc_cyc = cyc;
    req_valid = 1'b0;
    if (conc >= 0) begin
      // lands on the edge that examines frame conc
      acc_valid = 1'b1; acc_idx = IW'(conc); acc_write = 1'b0;
      @(posedge clk); #1;
      acc_valid = 1'b0;
      m_used[conc] = 1;
    end
    if (hold > 0) begin
      while (!vic_valid) begin @(posedge clk); #1; end
      held = vic_idx;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check(vic_valid && vic_idx == held, "R11", "stalled result moved",
              int'(vic_idx), int'(held));
        check(!req_ready, "R2", "ready while result pending", int'(req_ready), 0);
      end
      @(posedge clk); #1;
      vic_ready = 1'b1;
    end
    while (pops < target) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr = 16'hACE1;
    do_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(vic_valid == 1'b0, "R1", "vic_valid after reset", int'(vic_valid), 0);
    check(wb_req_valid == 1'b0, "R1", "wb_req_valid after reset", int'(wb_req_valid), 0);
    @(posedge clk); #1;

    request("R1 R5", 0, -1);                       // frame 0 at once
    mark(1, 0); mark(2, 0);
    request("R4", 0, -1);                          // used frames skipped
    mark(4, 1);
    request("R7", 0, -1);                          // write marks used and modified
    mark(5, 0); mark(6, 0); mark(7, 0); mark(0, 0);
    mark(1, 0); mark(2, 0); mark(3, 0);
    request("R6", 0, -1);                          // modified frame gets a pulse
    for (int i = 0; i < NF; i++) mark(i, 1);
    ack(2);
    request("R8", 0, -1);                          // acknowledged frame turns clean
    for (int i = 0; i < NF; i++) mark(i, 1);
    request("R10 R11", 3, -1);                     // forced pick, stalled result

    do_reset();
    mark(0, 0); mark(1, 0);
    request("R9", 0, 0);                           // mark collides with clear
    for (int i = 3; i < NF; i++) mark(i, 0);
    request("R9", 0, -1);                          // frame 0 still used: frame 1 chosen

    for (int it = 0; it < 40; it++) begin
      for (int op = 0; op < 3; op++) begin
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
        case (lfsr % 3)
          0: mark((lfsr >> 4) % NF, 0);
          1: mark((lfsr >> 4) % NF, 1);
          default: ack((lfsr >> 4) % NF);
        endcase
      end
      request("R3 R5", (it % 7 == 3) ? 2 : 0, -1);
    end

    repeat (3) @(posedge clk);
    check(wbq.size() == 0, "R6", "missing write-back pulses", wbq.size(), 0);
    check(exp_idx.size() == 0, "R3", "missing results", exp_idx.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule